// File: doc/BRIEF.md
# NAND Sector SEC-DED Code Checker

This block checks one 512-byte NAND flash sector against the error-correcting code that was written with it. After a command pulse, data bytes stream in with a valid strobe. A 24-bit line/column code is built on the fly from those bytes: a 12-bit parity half and a 12-bit complement half. Once the 512th byte is taken, the computed code is frozen. The code read back from the spare area is then presented with its own strobe.

One cycle after that strobe, the block pulses `done`. The XOR of the two codes (the syndrome) is sorted into one of four outcomes:
- a clean sector;
- a single correctable data-bit error, reported with its byte offset and bit index;
- a single-bit fault inside the stored code itself;
- an uncorrectable multiple error.

Any new command pulse or a software reset clears the reported status. The block does not repair the data buffer. The host uses the reported offset to flip the bad bit.

Top module: `nand_secded_checker`

## Requirements
- R1: The computed code is 24 bits. For each k in 0..11, bit k is the XOR of every data bit whose position index (byte offset × 8 + bit number) has bit k equal to 1. Bit 12+k is the XOR of every data bit whose position index has bit k equal to 0.
- R2: A `cmd_start` pulse discards any partial accumulation and opens a new sector. A byte presented in the same cycle as `cmd_start`, or before the first `cmd_start`, is not accumulated.
- R3: The computed code is frozen after exactly 512 accepted bytes. Bytes presented after that do not change it.
- R4: `code_valid` is accepted only while the code is frozen and neither `cmd_start` nor `sw_rst` is high. An accepted strobe makes `done` high for exactly the following cycle. A strobe that is not accepted produces no `done`.
- R5: A zero syndrome reports `done` with `recov_err`, `code_err` and `multi_err` all 0, and `err_word` and `err_bit` equal to 0.
- R6: A syndrome whose parity half XOR complement half equals all ones sets only `recov_err`. It reports `err_word` = syndrome bits [11:3] and `err_bit` = syndrome bits [2:0].
- R7: A syndrome with exactly one bit set sets only `code_err`, and both address fields read 0.
- R8: Any other nonzero syndrome sets only `multi_err`, and both address fields read 0.
- R9: `cmd_start` or `sw_rst` clears all flags and address fields on the next edge. `sw_rst` also abandons the sector, so strobes are ignored until a new full sector has been accepted.
- R10: The synchronous active-low `rst_n` clears all outputs, and the block ignores strobes until a sector is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Software reset pulse, clears status and abandons the sector |
| cmd_start | input | 1 | Read/write command pulse, opens a new sector |
| din | input | 8 | Data byte |
| din_valid | input | 1 | Data byte strobe |
| code_in | input | 24 | Code read back from the spare area |
| code_valid | input | 1 | Stored-code strobe |
| done | output | 1 | One-cycle classification pulse |
| recov_err | output | 1 | Single correctable data error |
| code_err | output | 1 | Single-bit error inside the stored code |
| multi_err | output | 1 | Uncorrectable error |
| err_word | output | 9 | Byte offset of the correctable error |
| err_bit | output | 3 | Bit index of the correctable error |

## Verification
Each byte is added to the code at the edge that samples it. The 512th byte freezes the code at that same edge. A strobe accepted at edge t drives `done`, the flags and the fields right after edge t, and only `done` falls after edge t+1. `cmd_start` and `sw_rst` clear status after the edge that samples them. The bench drives inputs on falling edges, checks the result on the falling edge right after the strobe edge, and checks the hold and the end of the pulse one falling edge later. Expected codes and addresses come from a bench model that applies the per-position definition of R1.

// File: rtl/nand_ecc_pkg.sv
// Package: shared types for the NAND sector code checker.
// Assumes: one sector is handled at a time; the classes are mutually exclusive.
package nand_ecc_pkg;

    // Outcome of comparing the computed code with the stored code
    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_RECOV = 2'd1,
        CLS_CODE  = 2'd2,
        CLS_MULTI = 2'd3
    } ecc_class_e;

    // Phase of the accumulator
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_RUN    = 2'd1,
        ACC_FROZEN = 2'd2
    } acc_state_e;

endpackage

// File: rtl/nand_ecc_accum.sv
// Module: nand_ecc_accum
// Builds the parity and complement-parity halves of the sector code one byte
// per accepted strobe. Each set data bit XORs its position index into the
// parity half and the complement of that index into the other half. After
// SECTOR_BYTES accepted bytes the code freezes until a new command.
// Assumes: SECTOR_BYTES and BYTE_W are powers of two; sw_rst has priority
// over cmd_start; a byte arriving with cmd_start is dropped.
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int BYTE_W       = 8,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int BIT_W       = $clog2(BYTE_W),
    localparam int POS_W       = ADDR_W + BIT_W,
    localparam int CODE_W      = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cmd_start,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_valid,
    output logic [CODE_W-1:0] code_o,
    output logic              frozen_o
);

    localparam logic [ADDR_W-1:0] LAST_BYTE = ADDR_W'(SECTOR_BYTES - 1);

    acc_state_e        state_q;
    logic [ADDR_W-1:0] byte_cnt_q;
    logic [POS_W-1:0]  par_q;
    logic [POS_W-1:0]  npar_q;

    // Per-bit contributions: position index (or its complement) if the bit is set
    logic [POS_W-1:0] pos_term  [BYTE_W];
    logic [POS_W-1:0] npos_term [BYTE_W];
    logic [POS_W-1:0] byte_par;
    logic [POS_W-1:0] byte_npar;
    logic             take_byte;

    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
        logic [POS_W-1:0] pos_j;
        // Position index of data bit j of the current byte
        assign pos_j        = {byte_cnt_q, BIT_W'(j)};
        assign pos_term[j]  = din[j] ? pos_j  : '0;
        assign npos_term[j] = din[j] ? ~pos_j : '0;
    end

    // XOR-reduce the per-bit contributions of the current byte
    always_comb begin
        byte_par  = '0;
        byte_npar = '0;
        for (int j = 0; j < BYTE_W; j++) begin
            byte_par  = byte_par  ^ pos_term[j];
            byte_npar = byte_npar ^ npos_term[j];
        end
    end

    assign take_byte = (state_q == ACC_RUN) && din_valid;

    // Sector phase, byte count and code halves
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            state_q    <= ACC_IDLE;
            byte_cnt_q <= '0;
            par_q      <= '0;
            npar_q     <= '0;
        end else if (cmd_start) begin
            state_q    <= ACC_RUN;
            byte_cnt_q <= '0;
            par_q      <= '0;
            npar_q     <= '0;
        end else if (take_byte) begin
            par_q  <= par_q  ^ byte_par;
            npar_q <= npar_q ^ byte_npar;
            if (byte_cnt_q == LAST_BYTE) begin
                state_q <= ACC_FROZEN;
            end else begin
                byte_cnt_q <= byte_cnt_q + 1'b1;
            end
        end
    end

    assign code_o   = {npar_q, par_q};
    assign frozen_o = (state_q == ACC_FROZEN);

endmodule

// File: rtl/nand_ecc_classify.sv
// Module: nand_ecc_classify
// Forms the syndrome of the computed and stored codes and sorts it into one of
// four classes. Also extracts the error position from the parity half.
// Assumes: code layout is {complement half, parity half}; purely combinational.
module nand_ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter int POS_W   = 12,
    localparam int CODE_W = 2 * POS_W
) (
    input  logic [CODE_W-1:0] computed_i,
    input  logic [CODE_W-1:0] stored_i,
    output ecc_class_e        class_o,
    output logic [POS_W-1:0]  pos_o
);

    logic [CODE_W-1:0] syn;
    logic [POS_W-1:0]  syn_par;
    logic [POS_W-1:0]  syn_npar;
    logic              pairs_split;
    logic              single_bit;

    assign syn         = computed_i ^ stored_i;
    assign syn_par     = syn[POS_W-1:0];
    assign syn_npar    = syn[CODE_W-1:POS_W];
    assign pairs_split = &(syn_par ^ syn_npar);
    assign single_bit  = $onehot(syn);

    // Decode the syndrome into a class; position only for correctable errors
    always_comb begin
        pos_o = '0;
        if (syn == '0) begin
            class_o = CLS_CLEAN;
        end else if (pairs_split) begin
            class_o = CLS_RECOV;
            pos_o   = syn_par;
        end else if (single_bit) begin
            class_o = CLS_CODE;
        end else begin
            class_o = CLS_MULTI;
        end
    end

endmodule

// File: rtl/nand_ecc_status.sv
// Module: nand_ecc_status
// Holds the status flags and error address of the last classification and
// produces the one-cycle done pulse.
// Assumes: clear_i has priority over load_i; fields are zero unless the
// class is recoverable.
module nand_ecc_status
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BIT_W  = 3,
    localparam int POS_W = ADDR_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  ecc_class_e        class_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic              done_o,
    output logic              recov_o,
    output logic              code_o,
    output logic              multi_o,
    output logic [ADDR_W-1:0] word_o,
    output logic [BIT_W-1:0]  bit_o
);

    // Status registers: clear, load on an accepted strobe, else hold
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            done_o  <= 1'b0;
            recov_o <= 1'b0;
            code_o  <= 1'b0;
            multi_o <= 1'b0;
            word_o  <= '0;
            bit_o   <= '0;
        end else if (load_i) begin
            done_o  <= 1'b1;
            recov_o <= (class_i == CLS_RECOV);
            code_o  <= (class_i == CLS_CODE);
            multi_o <= (class_i == CLS_MULTI);
            word_o  <= pos_i[POS_W-1:BIT_W];
            bit_o   <= pos_i[BIT_W-1:0];
        end else begin
            done_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/nand_secded_checker.sv
// Module: nand_secded_checker (top)
// Checks one NAND sector against its stored SEC-DED line/column code.
// Assumes: the host issues cmd_start before each sector and presents the
// stored code after the full sector; the data buffer is repaired by the host.
module nand_secded_checker
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int BYTE_W       = 8,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int BIT_W       = $clog2(BYTE_W),
    localparam int POS_W       = ADDR_W + BIT_W,
    localparam int CODE_W      = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cmd_start,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_valid,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_valid,
    output logic              done,
    output logic              recov_err,
    output logic              code_err,
    output logic              multi_err,
    output logic [ADDR_W-1:0] err_word,
    output logic [BIT_W-1:0]  err_bit
);

    logic [CODE_W-1:0] computed_w;
    logic              frozen_w;
    ecc_class_e        class_w;
    logic [POS_W-1:0]  pos_w;
    logic              accept_w;
    logic              clear_w;

    assign clear_w  = sw_rst | cmd_start;
    assign accept_w = code_valid & frozen_w & ~clear_w;

    nand_ecc_accum #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .BYTE_W       (BYTE_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .cmd_start (cmd_start),
        .din       (din),
        .din_valid (din_valid),
        .code_o    (computed_w),
        .frozen_o  (frozen_w)
    );

    nand_ecc_classify #(
        .POS_W (POS_W)
    ) u_classify (
        .computed_i (computed_w),
        .stored_i   (code_in),
        .class_o    (class_w),
        .pos_o      (pos_w)
    );

    nand_ecc_status #(
        .ADDR_W (ADDR_W),
        .BIT_W  (BIT_W)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_w),
        .load_i  (accept_w),
        .class_i (class_w),
        .pos_i   (pos_w),
        .done_o  (done),
        .recov_o (recov_err),
        .code_o  (code_err),
        .multi_o (multi_err),
        .word_o  (err_word),
        .bit_o   (err_bit)
    );

endmodule

// File: rtl/nand_secded_checker_sva.sv
// Module: nand_secded_checker_sva
// Protocol and status checks for nand_secded_checker, attached by bind.
// Assumes: observes ports and the accumulator's frozen indication only.
module nand_secded_checker_sva #(
    parameter int ADDR_W = 9,
    parameter int BIT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              cmd_start,
    input logic              code_valid,
    input logic              frozen,
    input logic              done,
    input logic              recov_err,
    input logic              code_err,
    input logic              multi_err,
    input logic [ADDR_W-1:0] err_word,
    input logic [BIT_W-1:0]  err_bit
);

    // R6 R7 R8: at most one class flag at any time
    a_r6_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({recov_err, code_err, multi_err}));

    // R4: done only follows a strobe taken while frozen
    a_r4_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(code_valid) && $past(frozen)));

    // R9: command pulse clears status on the next edge
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!done && !recov_err && !code_err && !multi_err
                       && err_word == '0 && err_bit == '0));

    // R9: software reset clears status and abandons the sector
    a_r9_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!done && !recov_err && !code_err && !multi_err && !frozen));

    // R3: a frozen code stays frozen until a new command or software reset
    a_r3_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !cmd_start && !sw_rst) |=> frozen);

    // R7 R8: address fields are zero unless a correctable error is reported
    a_r8_fields_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !recov_err |-> (err_word == '0 && err_bit == '0));

endmodule

bind nand_secded_checker nand_secded_checker_sva #(
    .ADDR_W (ADDR_W),
    .BIT_W  (BIT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .cmd_start  (cmd_start),
    .code_valid (code_valid),
    .frozen     (frozen_w),
    .done       (done),
    .recov_err  (recov_err),
    .code_err   (code_err),
    .multi_err  (multi_err),
    .err_word   (err_word),
    .err_bit    (err_bit)
);

// File: tb/nand_secded_checker_bench.sv
`timescale 1ns/1ps
// Directed bench for nand_secded_checker: one task per scenario.
module nand_secded_checker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        cmd_start = 1'b0;
    logic [7:0]  din = '0;
    logic        din_valid = 1'b0;
    logic [23:0] code_in = '0;
    logic        code_valid = 1'b0;
    logic        done, recov_err, code_err, multi_err;
    logic [8:0]  err_word;
    logic [2:0]  err_bit;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] ref_mem [512];
    logic [7:0] tx_mem  [512];

    always #2 clk = ~clk;

    nand_secded_checker u_nand_secded_checker (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cmd_start(cmd_start),
        .din(din), .din_valid(din_valid), .code_in(code_in),
        .code_valid(code_valid), .done(done), .recov_err(recov_err),
        .code_err(code_err), .multi_err(multi_err),
        .err_word(err_word), .err_bit(err_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R1 model: per-position definition of both code halves
    function automatic logic [23:0] model_code();
        logic [11:0] p = '0;
        logic [11:0] n = '0;
        for (int pos = 0; pos < 4096; pos++) begin
            if (ref_mem[pos / 8][pos % 8]) begin
                for (int k = 0; k < 12; k++) begin
                    if (pos[k]) p[k] = ~p[k];
                    else        n[k] = ~n[k];
                end
            end
        end
        return {n, p};
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 512; i++) begin
            ref_mem[i] = 8'((i * seed) ^ (i >> 3) ^ seed);
            tx_mem[i]  = ref_mem[i];
        end
    endtask

    // Command pulse, then the first n bytes of tx_mem
    task automatic send(input int n);
        @(negedge clk);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            din = tx_mem[i];
            din_valid = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
    endtask

    // Strobe a code and check flags right after the strobe edge and one cycle on
    task automatic strobe_check(input logic [23:0] code, input string req,
                                input bit exp_done, input logic [2:0] exp_flags,
                                input int exp_word, input int exp_bit);
        code_in = code;
        code_valid = 1'b1;
        @(negedge clk);
        code_valid = 1'b0;
        chk(done == exp_done, {req, " done"}, done, exp_done);
        chk({recov_err, code_err, multi_err} == exp_flags, {req, " flags"},
            {recov_err, code_err, multi_err}, exp_flags);
        chk(err_word == exp_word && err_bit == exp_bit, {req, " address"},
            {err_word, err_bit}, (exp_word << 3) | exp_bit);
        @(negedge clk);
        chk(done == 1'b0, {req, " done pulse ends"}, done, 0);
        chk({recov_err, code_err, multi_err} == exp_flags, {req, " flags held"},
            {recov_err, code_err, multi_err}, exp_flags);
    endtask

    task automatic t_reset();
        chk({done, recov_err, code_err, multi_err} == 4'b0, "R10 reset flags",
            {done, recov_err, code_err, multi_err}, 0);
        chk(err_word == 0 && err_bit == 0, "R10 reset address", {err_word, err_bit}, 0);
        strobe_check(24'h123456, "R10 strobe before any sector", 1'b0, 3'b000, 0, 0);
    endtask

    task automatic t_clean(input int seed);
        fill(seed);
        send(512);
        strobe_check(model_code(), "R1 R5 clean sector", 1'b1, 3'b000, 0, 0);
    endtask

    task automatic t_recov(input int seed, input int b, input int bt);
        fill(seed);
        tx_mem[b][bt] = ~tx_mem[b][bt];
        send(512);
        strobe_check(model_code(), "R6 correctable error", 1'b1, 3'b100, b, bt);
    endtask

    task automatic t_code_err(input int seed, input int k);
        logic [23:0] c;
        fill(seed);
        send(512);
        c = model_code();
        c[k] = ~c[k];
        strobe_check(c, "R7 stored code error", 1'b1, 3'b010, 0, 0);
    endtask

    task automatic t_multi(input int seed);
        fill(seed);
        tx_mem[10][1] = ~tx_mem[10][1];
        tx_mem[400][6] = ~tx_mem[400][6];
        send(512);
        strobe_check(model_code(), "R8 double data error", 1'b1, 3'b001, 0, 0);
    endtask

    // Bytes before the start, with the start pulse, and after the 512th are dropped
    task automatic t_ignore(input int seed);
        fill(seed);
        @(negedge clk);
        din = 8'hFF; din_valid = 1'b1;
        @(negedge clk);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < 512; i++) begin
            din = tx_mem[i];
            @(negedge clk);
        end
        for (int i = 0; i < 5; i++) begin
            din = 8'hA5;
            @(negedge clk);
        end
        din_valid = 1'b0;
        strobe_check(model_code(), "R2 R3 extra bytes ignored", 1'b1, 3'b000, 0, 0);
    endtask

    task automatic t_early_strobe(input int seed);
        fill(seed);
        send(100);
        strobe_check(model_code(), "R4 strobe before sector complete", 1'b0, 3'b000, 0, 0);
    endtask

    task automatic t_clears(input int seed);
        fill(seed);
        tx_mem[3][3] = ~tx_mem[3][3];
        send(512);
        strobe_check(model_code(), "R6 setup for clear", 1'b1, 3'b100, 3, 3);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk({recov_err, err_word, err_bit} == 0, "R9 command clears status",
            {recov_err, err_word, err_bit}, 0);
        send(512);
        strobe_check(model_code(), "R6 setup for software reset", 1'b1, 3'b100, 3, 3);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        chk({recov_err, err_word, err_bit} == 0, "R9 software reset clears status",
            {recov_err, err_word, err_bit}, 0);
        strobe_check(model_code(), "R9 strobe after software reset", 1'b0, 3'b000, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(37);
        t_clean(0);
        t_recov(91, 300, 5);
        t_recov(13, 0, 0);
        t_recov(77, 511, 7);
        t_code_err(55, 0);
        t_code_err(55, 23);
        t_multi(29);
        t_ignore(61);
        t_early_strobe(17);
        t_clears(45);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule